// File: doc/BRIEF.md
# Planar Write Data Pipeline

This block forms the data and per-plane write strobes for a video memory that holds four byte-wide planes side by side in each 32-bit word. A host write supplies one byte. The block turns that byte into a full 32-bit word by passing it through five steps in a fixed order. First it rotates the byte. Next it copies the byte into every plane, replacing chosen planes with an all-zeros or all-ones constant. Then it combines the result with the 32-bit read latch under a chosen logic function. After that a bit mask picks, bit by bit, between this result and the latch. Last, a plane enable decides which planes are actually stored.

The path from the host write to the memory data and strobes is purely combinational. The settings that steer it live in a small bank of registers, which is loaded through a simple write port. Every register is zero after reset, and a setting takes effect from the clock edge that loads it. Only the plain write mode (mode 0) is carried out. With any other mode selected, the block withholds all strobes.

Top module: `planar_write_pipe`

## Requirements
- R1: After reset every setting is zero. Zero means rotate 0, no set/reset planes, pass-through logic, bit mask 0x00, plane enable 0x0 and write mode 0. So mem_wdata equals latch_in and plane_strobe is 0 even while wr_req is 1.
- R2: The host byte is rotated right by the rotate count (0..7). Bit 0 wraps into bit 7, and a count of 0 leaves the byte as it is.
- R3: Plane p occupies mem_wdata[8p+7:8p] and latch_in[8p+7:8p]. The rotated byte is copied into every plane that has no set/reset substitution.
- R4: A plane whose set/reset enable bit (bit p) is 1 takes 0x00 or 0xFF, as its set/reset bit p is 0 or 1. It does this in place of the rotated byte.
- R5: The logic setting combines each plane byte with that plane's latch byte. The codes are 0 for pass-through, 1 for AND, 2 for OR and 3 for XOR.
- R6: For each bit position b, mask bit b set to 1 places the logic result in bit b of every plane. Mask bit b set to 0 places latch bit b of that plane there.
- R7: plane_strobe equals the plane enable setting (bit p for plane p) while wr_req is 1 and the write mode is 0. It is 0 while wr_req is 0.
- R8: While the write mode setting is 1, 2 or 3, plane_strobe is 0 whatever wr_req and the plane enable are.
- R9: Register writes use cfg_addr and take effect at the next rising edge. The addresses are 0 rotate count [2:0], 1 set/reset [3:0], 2 set/reset enable [3:0], 3 logic [1:0], 4 bit mask [7:0], 5 plane enable [3:0] and 6 write mode [1:0]. Data bits above a field are ignored, and address 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the settings bank |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 3 | Settings register select |
| cfg_wdata | input | 8 | Settings write data |
| wr_req | input | 1 | Host write in progress |
| host_byte | input | 8 | Host write data byte |
| latch_in | input | 32 | Read latch contents, one byte per plane |
| mem_wdata | output | 32 | Data word for the video memory |
| plane_strobe | output | 4 | Per-plane write enable |

## Verification
The only state in the block is its settings bank. A wrong setting shows on the ports as soon as the next input pattern is applied: in the same cycle as the host write, and no later than one clock after the register write that set it. A corrupted rotate count or set/reset field shows up as a shifted or constant plane byte. A wrong logic code or mask shows up as latch bits leaking into, or missing from, mem_wdata. A wrong plane enable or mode shows up at once on plane_strobe. The sweeps cover every rotate count against every byte, every set/reset enable and value pair, all four logic codes, all 256 masks, every plane enable and every mode, each against a bench model.

// File: rtl/planar_write_pkg.sv
package planar_write_pkg;

    localparam int BYTE_W  = 8;
    localparam int PLANES  = 4;
    localparam int ROT_W   = $clog2(BYTE_W);
    localparam int WORD_W  = BYTE_W * PLANES;
    localparam int ADDR_W  = 3;
    localparam int MODE_W  = 2;

    typedef enum logic [1:0] {
        LOP_PASS = 2'd0,
        LOP_AND  = 2'd1,
        LOP_OR   = 2'd2,
        LOP_XOR  = 2'd3
    } logic_op_e;

    localparam logic [ADDR_W-1:0] A_ROT    = 3'd0;
    localparam logic [ADDR_W-1:0] A_SR     = 3'd1;
    localparam logic [ADDR_W-1:0] A_SR_EN  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOP    = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;
    localparam logic [ADDR_W-1:0] A_PLANE  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MODE   = 3'd6;

    typedef struct packed {
        logic [ROT_W-1:0]  rot;
        logic [PLANES-1:0] sr_val;
        logic [PLANES-1:0] sr_en;
        logic_op_e         lop;
        logic [BYTE_W-1:0] mask;
        logic [PLANES-1:0] plane_en;
        logic [MODE_W-1:0] mode;
    } wr_cfg_t;

endpackage

// File: rtl/pw_cfg_bank.sv
module pw_cfg_bank
    import planar_write_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output wr_cfg_t           cfg
);

    wr_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                A_ROT:   cfg_d.rot      = cfg_wdata[ROT_W-1:0];
                A_SR:    cfg_d.sr_val   = cfg_wdata[PLANES-1:0];
                A_SR_EN: cfg_d.sr_en    = cfg_wdata[PLANES-1:0];
                A_LOP:   cfg_d.lop      = logic_op_e'(cfg_wdata[1:0]);
                A_MASK:  cfg_d.mask     = cfg_wdata;
                A_PLANE: cfg_d.plane_en = cfg_wdata[PLANES-1:0];
                A_MODE:  cfg_d.mode     = cfg_wdata[MODE_W-1:0];
                default: cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R9: settings only move on a register write
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

endmodule

// File: rtl/pw_rotator.sv
module pw_rotator
    import planar_write_pkg::*;
#(
    parameter int W   = BYTE_W,
    parameter int CW  = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] count,
    output logic [W-1:0]  dout
);

    // right rotation: output bit i comes from input bit (i + count) mod W
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [CW-1:0] src;
        assign src     = CW'(i) + count;
        assign dout[i] = din[src];
    end

endmodule

// File: rtl/pw_plane_source.sv
module pw_plane_source
    import planar_write_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int P = PLANES
) (
    input  logic [W-1:0]   byte_in,
    input  logic [P-1:0]   sr_en,
    input  logic [P-1:0]   sr_val,
    output logic [W*P-1:0] planes
);

    for (genvar p = 0; p < P; p++) begin : g_plane
        always_comb begin
            if (sr_en[p]) planes[p*W +: W] = {W{sr_val[p]}};
            else          planes[p*W +: W] = byte_in;
        end
    end

endmodule

// File: rtl/pw_combine.sv
module pw_combine
    import planar_write_pkg::*;
#(
    parameter int W = BYTE_W,
    parameter int P = PLANES
) (
    input  logic [W*P-1:0] src,
    input  logic [W*P-1:0] latch,
    input  logic_op_e      lop,
    input  logic [W-1:0]   mask,
    output logic [W*P-1:0] result
);

    for (genvar p = 0; p < P; p++) begin : g_plane
        logic [W-1:0] a, l, r;
        assign a = src[p*W +: W];
        assign l = latch[p*W +: W];
        always_comb begin
            case (lop)
                LOP_AND: r = a & l;
                LOP_OR:  r = a | l;
                LOP_XOR: r = a ^ l;
                default: r = a;
            endcase
        end
        assign result[p*W +: W] = (r & mask) | (l & ~mask);
    end

endmodule

// File: rtl/planar_write_pipe.sv
module planar_write_pipe
    import planar_write_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              wr_req,
    input  logic [7:0]        host_byte,
    input  logic [31:0]       latch_in,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        plane_strobe
);

    wr_cfg_t             cfg;
    logic [BYTE_W-1:0]   rot_byte;
    logic [WORD_W-1:0]   plane_src;

    pw_cfg_bank u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    pw_rotator #(.W(BYTE_W), .CW(ROT_W)) u_rot (
        .din   (host_byte),
        .count (cfg.rot),
        .dout  (rot_byte)
    );

    pw_plane_source #(.W(BYTE_W), .P(PLANES)) u_src (
        .byte_in (rot_byte),
        .sr_en   (cfg.sr_en),
        .sr_val  (cfg.sr_val),
        .planes  (plane_src)
    );

    pw_combine #(.W(BYTE_W), .P(PLANES)) u_comb (
        .src    (plane_src),
        .latch  (latch_in),
        .lop    (cfg.lop),
        .mask   (cfg.mask),
        .result (mem_wdata)
    );

    always_comb begin
        plane_strobe = '0;
        if (wr_req && (cfg.mode == '0)) plane_strobe = cfg.plane_en;
    end

    // R2: zero count leaves the host byte untouched
    assert_rot_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.rot == '0) |-> (rot_byte == host_byte));

    // R6: masked-off bit positions always carry the latch
    assert_mask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (((mem_wdata ^ latch_in) & ~{PLANES{cfg.mask}}) == '0));

    // R7: no strobe without a host write
    assert_strobe_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |-> (plane_strobe == '0));

    // R8: other write modes never store
    assert_mode_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode != '0) |-> (plane_strobe == '0));

endmodule

// File: tb/planar_write_pipe_tb.sv
module planar_write_pipe_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        wr_req = 1'b0;
    logic [7:0]  host_byte = '0;
    logic [31:0] latch_in = '0;
    logic [31:0] mem_wdata;
    logic [3:0]  plane_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench copy of the settings, tracked from the writes it issues
    logic [2:0] m_rot = '0;
    logic [3:0] m_sr = '0, m_sren = '0, m_pen = '0;
    logic [1:0] m_lop = '0, m_mode = '0;
    logic [7:0] m_mask = '0;

    always #2.5 clk = ~clk;

    planar_write_pipe u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .wr_req(wr_req), .host_byte(host_byte),
        .latch_in(latch_in), .mem_wdata(mem_wdata), .plane_strobe(plane_strobe)
    );

    function automatic logic [31:0] exp_data(logic [7:0] hb, logic [31:0] lat);
        logic [15:0] dbl;
        logic [7:0]  rb, a, l, r;
        logic [31:0] res;
        dbl = {hb, hb} >> m_rot;
        rb  = dbl[7:0];
        for (int p = 0; p < 4; p++) begin
            a = m_sren[p] ? (m_sr[p] ? 8'hFF : 8'h00) : rb;
            l = lat[p*8 +: 8];
            case (m_lop)
                2'd1: r = a & l;
                2'd2: r = a | l;
                2'd3: r = a ^ l;
                default: r = a;
            endcase
            res[p*8 +: 8] = (r & m_mask) | (l & ~m_mask);
        end
        return res;
    endfunction

    task automatic wcfg(input logic [2:0] addr, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (addr)
            3'd0: m_rot  = data[2:0];
            3'd1: m_sr   = data[3:0];
            3'd2: m_sren = data[3:0];
            3'd3: m_lop  = data[1:0];
            3'd4: m_mask = data;
            3'd5: m_pen  = data[3:0];
            3'd6: m_mode = data[1:0];
            default: ;
        endcase
    endtask

    task automatic chk(input string tag, input logic req, input logic [7:0] hb,
                       input logic [31:0] lat);
        logic [31:0] ed;
        logic [3:0]  es;
        wr_req = req; host_byte = hb; latch_in = lat;
        #0.5;
        ed = exp_data(hb, lat);
        es = (req && m_mode == 2'd0) ? m_pen : 4'h0;
        checks++;
        if (mem_wdata !== ed || plane_strobe !== es) begin
            errors++;
            $display("FAIL %s data %h strobe %h expected data %h strobe %h",
                     tag, mem_wdata, plane_strobe, ed, es);
        end
    endtask

    function automatic logic [31:0] pat(int i);
        return 32'h9E3779B9 * (i + 1) ^ 32'h5A0FC3E1;
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values: data is the latch, no strobes
        chk("R1", 1'b1, 8'hA5, 32'h12345678);
        chk("R1", 1'b0, 8'h3C, 32'hCAFEF00D);

        wcfg(3'd4, 8'hFF);
        wcfg(3'd5, 8'hF);
        // R2 R3: every count against every byte, copied to all planes
        for (int c = 0; c < 8; c++) begin
            wcfg(3'd0, 8'(c));
            for (int b = 0; b < 256; b++) chk("R2_R3", 1'b1, 8'(b), pat(b));
        end

        // R4: every enable and value pair
        wcfg(3'd0, 8'd3);
        for (int e = 0; e < 16; e++) begin
            wcfg(3'd2, 8'(e));
            for (int s = 0; s < 16; s++) begin
                wcfg(3'd1, 8'(s));
                for (int k = 0; k < 3; k++) chk("R4", 1'b1, 8'(s * 17 + k * 5), pat(e * 16 + s + k));
            end
        end

        // R5: all logic codes, with a mixed set/reset arrangement
        wcfg(3'd2, 8'h5);
        wcfg(3'd1, 8'h4);
        for (int o = 0; o < 4; o++) begin
            wcfg(3'd3, 8'(o));
            for (int i = 0; i < 64; i++) chk("R5", 1'b1, 8'(i * 37), pat(i + o * 64));
        end

        // R6: every mask under XOR
        wcfg(3'd2, 8'h0);
        wcfg(3'd3, 8'd3);
        for (int m = 0; m < 256; m++) begin
            wcfg(3'd4, 8'(m));
            chk("R6", 1'b1, 8'(m ^ 8'h6B), pat(m));
            chk("R6", 1'b1, 8'(m + 1), 32'hFFFF0000);
        end

        // R7: every plane enable with and without a request
        for (int p = 0; p < 16; p++) begin
            wcfg(3'd5, 8'(p));
            chk("R7", 1'b1, 8'h81, pat(p));
            chk("R7", 1'b0, 8'h81, pat(p));
        end

        // R8: nonzero modes block strobes, mode 0 restores them
        wcfg(3'd5, 8'hF);
        for (int md = 1; md < 4; md++) begin
            wcfg(3'd6, 8'(md));
            chk("R8", 1'b1, 8'h42, pat(md));
        end
        wcfg(3'd6, 8'h0);
        chk("R8", 1'b1, 8'h42, pat(9));

        // R9: address 7 changes nothing; high data bits ignored
        wcfg(3'd7, 8'hFF);
        chk("R9", 1'b1, 8'h96, pat(11));
        wcfg(3'd0, 8'hF9);
        chk("R9", 1'b1, 8'h96, pat(12));
        wcfg(3'd5, 8'hF2);
        chk("R9", 1'b1, 8'h96, pat(13));
        wcfg(3'd3, 8'hFC);
        chk("R9", 1'b1, 8'h96, pat(14));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule